// File: doc/BRIEF.md
# Page-Bias Access Gate

This block sits between an accelerator's compute engines and the accelerator's own local memory. Every memory access from the device side is steered by a one-bit bias flag kept for the page that the access falls in. If the page is marked as owned by the device, the access goes straight to local memory and the host is not involved. If the page is marked as shared with the host, the block first asks the host to settle coherence for that address. If the host holds a modified copy, the host returns the data and drops its own copy. The block commits that data to local memory and then carries out the original access.

Control logic flips the flag of a page through a small command port. A page is set to device-owned for a compute phase, and set back to host-shared before the host collects results. Only one host resolution can be in flight at a time. A flag change aimed at the page being resolved is held off until the resolution ends, so a flip never overtakes an access.

Top module: `pbg_bias_gate`

## Requirements
- R1: After reset all 16 pages are host-shared (flag 0). No request is presented on the memory or host ports, `dev_rvalid` is low and `bc_ready` is high.
- R2: The page of an access is `dev_addr[15:12]`, so 0x3FF8 and 0x4000 fall in different pages. A command with `bc_bias`=1 marks a page device-owned and `bc_bias`=0 marks it host-shared. A command takes effect for accesses accepted after its handshake cycle, and it can also return a page to host-shared.
- R3: An access to a device-owned page is presented to the memory port in the same cycle, with `dev_ready` following `mem_ready`. It raises no host request.
- R4: An access to a host-shared page is accepted at once and raises exactly one host request carrying the access address. That request holds steady until `hreq_ready`. Local memory is not touched until the host response arrives, and then the original access is issued to memory.
- R5: A host response code of 2'b01 (modified) makes the block write `hrsp_data` to the access address in local memory before the original access. A code of 2'b00 (clean) causes no write-back.
- R6: At most one host resolution is outstanding. `dev_ready` stays low from the acceptance of a host-shared access until memory accepts that access.
- R7: A bias command for the page under resolution sees `bc_ready` low until the resolution ends, and so does one for the page of a host-shared access being accepted in the same cycle. Commands for other pages are accepted at once.
- R8: `dev_rvalid` is high exactly in the cycle after the memory port accepts a device read, with `dev_rdata` equal to `mem_rdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_valid | input | 1 | Device access request |
| dev_ready | output | 1 | Device access accepted |
| dev_we | input | 1 | 1 = write, 0 = read |
| dev_addr | input | 16 | Byte address of the access |
| dev_wdata | input | 64 | Write data |
| dev_rvalid | output | 1 | Read data valid |
| dev_rdata | output | 64 | Read data |
| hreq_valid | output | 1 | Coherence request to host |
| hreq_ready | input | 1 | Host accepts the request |
| hreq_addr | output | 16 | Address to resolve |
| hrsp_valid | input | 1 | Host response strobe |
| hrsp_code | input | 2 | 00 clean, 01 modified with data |
| hrsp_data | input | 64 | Modified line data |
| mem_valid | output | 1 | Local memory request |
| mem_ready | input | 1 | Local memory accepts |
| mem_we | output | 1 | Local memory write |
| mem_addr | output | 16 | Local memory address |
| mem_wdata | output | 64 | Local memory write data |
| mem_rdata | input | 64 | Read data, valid the cycle after accept |
| bc_valid | input | 1 | Bias change command |
| bc_ready | output | 1 | Command accepted |
| bc_page | input | 4 | Page to change |
| bc_bias | input | 1 | 1 device-owned, 0 host-shared |

## Verification
Four patterns are tried.

- A sweep of all sixteen pages straight after reset shows that every page starts host-shared, because each access must raise one host request.
- Reads and writes to device-owned pages, and an access on each side of a page boundary, separate the direct route from the host route by the count of host requests.
- Accesses to lines that the host holds modified, mixed with clean ones, separate the write-back route from the plain replay: the returned read data and the final memory contents differ between them.
- A long interleaving of both kinds of page under random-looking stalls on both memory and host ports, with bias commands aimed at the busy page and at an idle page, exposes ordering faults: an early memory touch, a second outstanding request, or a flip that overtakes an access.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_HREQ,
    RS_HWAIT,
    RS_WB,
    RS_REPLAY
  } rs_state_e;

  localparam logic [1:0] HC_CLEAN    = 2'b00;
  localparam logic [1:0] HC_MODIFIED = 2'b01;

  localparam logic BIAS_HOST = 1'b0;
  localparam logic BIAS_DEV  = 1'b1;

endpackage

// File: rtl/pbg_bias_table.sv
module pbg_bias_table
  import pbg_pkg::*;
#(
  parameter int NPAGES = 16,
  parameter int PIDX_W = $clog2(NPAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIDX_W-1:0] rd_page,
  output logic              rd_is_dev,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_page,
  input  logic              wr_bias
);

  logic [NPAGES-1:0] bias_q;
  logic [NPAGES-1:0] bias_d;
  logic [NPAGES-1:0] bias_en;

  for (genvar g = 0; g < NPAGES; g++) begin : g_entry
    always_comb begin
      bias_en[g] = wr_en && (wr_page == PIDX_W'(g));
      bias_d[g]  = wr_bias;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bias_q[g] <= BIAS_HOST;
      end else if (bias_en[g]) begin
        bias_q[g] <= bias_d[g];
      end
    end
  end

  assign rd_is_dev = (bias_q[rd_page] == BIAS_DEV);

endmodule

// File: rtl/pbg_resolver.sv
module pbg_resolver
  import pbg_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_valid,
  input  logic          dev_we,
  input  logic [AW-1:0] dev_addr,
  input  logic [DW-1:0] dev_wdata,
  input  logic          page_is_dev,
  input  logic          mem_ready,
  input  logic          hreq_ready,
  input  logic          hrsp_valid,
  input  logic [1:0]    hrsp_code,
  input  logic [DW-1:0] hrsp_data,
  output logic          dev_ready,
  output logic          direct_en,
  output logic          claim,
  output logic          busy,
  output logic          hreq_valid,
  output logic [AW-1:0] hreq_addr,
  output logic          wb_valid,
  output logic          rp_valid,
  output logic          hold_we,
  output logic [AW-1:0] hold_addr,
  output logic [DW-1:0] hold_wdata,
  output logic [DW-1:0] wb_data
);

  rs_state_e     st_q, st_d;
  logic          wb_load;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] wbd_q;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    claim   = 1'b0;
    wb_load = 1'b0;
    unique case (st_q)
      RS_IDLE: begin
        if (dev_valid && !page_is_dev) begin
          claim = 1'b1;
          st_d  = RS_HREQ;
        end
      end
      RS_HREQ: begin
        if (hreq_ready) st_d = RS_HWAIT;
      end
      RS_HWAIT: begin
        if (hrsp_valid) begin
          if (hrsp_code == HC_MODIFIED) begin
            wb_load = 1'b1;
            st_d    = RS_WB;
          end else begin
            st_d = RS_REPLAY;
          end
        end
      end
      RS_WB: begin
        if (mem_ready) st_d = RS_REPLAY;
      end
      RS_REPLAY: begin
        if (mem_ready) st_d = RS_IDLE;
      end
      default: st_d = RS_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_IDLE;
    else        st_q <= st_d;
  end

  // held access, loaded on claim
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (claim) begin
      we_q   <= dev_we;
      addr_q <= dev_addr;
      wd_q   <= dev_wdata;
    end
  end

  // write-back beat, loaded on a modified response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wbd_q <= '0;
    else if (wb_load) wbd_q <= hrsp_data;
  end

  assign direct_en  = (st_q == RS_IDLE) && page_is_dev;
  assign dev_ready  = (st_q == RS_IDLE) && (page_is_dev ? mem_ready : 1'b1);
  assign busy       = (st_q != RS_IDLE);
  assign hreq_valid = (st_q == RS_HREQ);
  assign hreq_addr  = addr_q;
  assign wb_valid   = (st_q == RS_WB);
  assign rp_valid   = (st_q == RS_REPLAY);
  assign hold_we    = we_q;
  assign hold_addr  = addr_q;
  assign hold_wdata = wd_q;
  assign wb_data    = wbd_q;

endmodule

// File: rtl/pbg_mem_path.sv
module pbg_mem_path #(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          direct_en,
  input  logic          dev_valid,
  input  logic          dev_we,
  input  logic [AW-1:0] dev_addr,
  input  logic [DW-1:0] dev_wdata,
  input  logic          wb_valid,
  input  logic [DW-1:0] wb_data,
  input  logic          rp_valid,
  input  logic          hold_we,
  input  logic [AW-1:0] hold_addr,
  input  logic [DW-1:0] hold_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          dev_rvalid,
  output logic [DW-1:0] dev_rdata
);

  logic rvalid_q, rvalid_d;

  // source select: write-back, then replay, then direct
  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = hold_addr;
    mem_wdata = hold_wdata;
    if (wb_valid) begin
      mem_valid = 1'b1;
      mem_we    = 1'b1;
      mem_wdata = wb_data;
    end else if (rp_valid) begin
      mem_valid = 1'b1;
      mem_we    = hold_we;
    end else if (direct_en) begin
      mem_valid = dev_valid;
      mem_we    = dev_we;
      mem_addr  = dev_addr;
      mem_wdata = dev_wdata;
    end
  end

  always_comb begin
    rvalid_d = mem_valid && mem_ready && !mem_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rvalid_d;
  end

  assign dev_rvalid = rvalid_q;
  assign dev_rdata  = mem_rdata;

endmodule

// File: rtl/pbg_bias_gate.sv
module pbg_bias_gate #(
  parameter int AW       = 16,
  parameter int DW       = 64,
  parameter int NPAGES   = 16,
  parameter int PAGE_LSB = 12,
  parameter int PIDX_W   = $clog2(NPAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_valid,
  output logic              dev_ready,
  input  logic              dev_we,
  input  logic [AW-1:0]     dev_addr,
  input  logic [DW-1:0]     dev_wdata,
  output logic              dev_rvalid,
  output logic [DW-1:0]     dev_rdata,
  output logic              hreq_valid,
  input  logic              hreq_ready,
  output logic [AW-1:0]     hreq_addr,
  input  logic              hrsp_valid,
  input  logic [1:0]        hrsp_code,
  input  logic [DW-1:0]     hrsp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              bc_valid,
  output logic              bc_ready,
  input  logic [PIDX_W-1:0] bc_page,
  input  logic              bc_bias
);

  logic [PIDX_W-1:0] dev_page;
  logic [PIDX_W-1:0] busy_page;
  logic              page_is_dev;
  logic              direct_en, claim, busy;
  logic              wb_valid, rp_valid, hold_we;
  logic [AW-1:0]     hold_addr;
  logic [DW-1:0]     hold_wdata, wb_data;
  logic              flip_clash;

  assign dev_page  = dev_addr[PAGE_LSB +: PIDX_W];
  assign busy_page = hold_addr[PAGE_LSB +: PIDX_W];

  // a flip waits while its page is being resolved or claimed this cycle
  always_comb begin
    flip_clash = (busy && (bc_page == busy_page)) ||
                 (claim && (bc_page == dev_page));
    bc_ready   = !flip_clash;
  end

  pbg_bias_table #(
    .NPAGES (NPAGES),
    .PIDX_W (PIDX_W)
  ) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_page   (dev_page),
    .rd_is_dev (page_is_dev),
    .wr_en     (bc_valid && bc_ready),
    .wr_page   (bc_page),
    .wr_bias   (bc_bias)
  );

  pbg_resolver #(
    .AW (AW),
    .DW (DW)
  ) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_valid   (dev_valid),
    .dev_we      (dev_we),
    .dev_addr    (dev_addr),
    .dev_wdata   (dev_wdata),
    .page_is_dev (page_is_dev),
    .mem_ready   (mem_ready),
    .hreq_ready  (hreq_ready),
    .hrsp_valid  (hrsp_valid),
    .hrsp_code   (hrsp_code),
    .hrsp_data   (hrsp_data),
    .dev_ready   (dev_ready),
    .direct_en   (direct_en),
    .claim       (claim),
    .busy        (busy),
    .hreq_valid  (hreq_valid),
    .hreq_addr   (hreq_addr),
    .wb_valid    (wb_valid),
    .rp_valid    (rp_valid),
    .hold_we     (hold_we),
    .hold_addr   (hold_addr),
    .hold_wdata  (hold_wdata),
    .wb_data     (wb_data)
  );

  pbg_mem_path #(
    .AW (AW),
    .DW (DW)
  ) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .direct_en  (direct_en),
    .dev_valid  (dev_valid),
    .dev_we     (dev_we),
    .dev_addr   (dev_addr),
    .dev_wdata  (dev_wdata),
    .wb_valid   (wb_valid),
    .wb_data    (wb_data),
    .rp_valid   (rp_valid),
    .hold_we    (hold_we),
    .hold_addr  (hold_addr),
    .hold_wdata (hold_wdata),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .mem_valid  (mem_valid),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .dev_rvalid (dev_rvalid),
    .dev_rdata  (dev_rdata)
  );

endmodule

// File: rtl/pbg_bias_gate_chk.sv
module pbg_bias_gate_chk
  import pbg_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 64,
  parameter int PAGE_LSB = 12,
  parameter int PIDX_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_ready,
  input logic              dev_rvalid,
  input logic              hreq_valid,
  input logic              hreq_ready,
  input logic [AW-1:0]     hreq_addr,
  input logic              hrsp_valid,
  input logic [1:0]        hrsp_code,
  input logic [DW-1:0]     hrsp_data,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [DW-1:0]     mem_wdata,
  input logic              bc_valid,
  input logic              bc_ready,
  input logic [PIDX_W-1:0] bc_page
);

  AST_HREQ_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid |-> !mem_valid); // R4

  AST_HREQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq_valid && !hreq_ready) |=> (hreq_valid && $stable(hreq_addr))); // R4

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid |-> !dev_ready); // R6

  AST_WB_AFTER_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (hrsp_valid && hrsp_code == HC_MODIFIED) |=>
      (mem_valid && mem_we && mem_wdata == $past(hrsp_data))); // R5

  AST_RD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_we) |=> dev_rvalid); // R8

  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && mem_ready && !mem_we) |=> !dev_rvalid); // R8

  AST_FLIP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && hreq_valid && bc_page == hreq_addr[PAGE_LSB +: PIDX_W]) |-> !bc_ready); // R7

endmodule

bind pbg_bias_gate pbg_bias_gate_chk #(
  .AW       (AW),
  .DW       (DW),
  .PAGE_LSB (PAGE_LSB),
  .PIDX_W   (PIDX_W)
) u_chk (.*);

// File: tb/tb_pbg_bias_gate.sv
`timescale 1ns/1ps
module tb_pbg_bias_gate;

  logic        clk;
  logic        rst_n;
  logic        dev_valid, dev_ready, dev_we, dev_rvalid;
  logic [15:0] dev_addr;
  logic [63:0] dev_wdata, dev_rdata;
  logic        hreq_valid, hreq_ready, hrsp_valid;
  logic [15:0] hreq_addr;
  logic [1:0]  hrsp_code;
  logic [63:0] hrsp_data;
  logic        mem_valid, mem_ready, mem_we;
  logic [15:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic        bc_valid, bc_ready, bc_bias;
  logic [3:0]  bc_page;

  pbg_bias_gate dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  int checks = 0;
  int errors = 0;

  // behavioural model state
  logic [63:0] mem      [int];   // actual memory behind the port
  logic [63:0] host_mod [int];   // host-side modified lines
  logic [63:0] ref_mem  [int];
  logic [63:0] ref_hmod [int];
  logic [15:0] ref_bias;
  logic [63:0] exp_q[$];
  int          act_hreq = 0, ref_hreq = 0, act_wr = 0, ref_wr = 0;

  // resolution phase: 0 idle, 1 host, 2 write-back, 3 replay
  int          phase;
  logic [15:0] ph_addr;
  logic        ph_we, ph_mod;
  logic [63:0] ph_wd, ph_wbd;
  logic        prev_rd;
  logic [63:0] rd_next;
  int          hdelay;
  logic [1:0]  h_code;
  logic [63:0] h_data;
  logic        mem_bp = 1'b0, host_bp = 1'b0;
  int          cyc;

  function automatic logic [63:0] dflt(input int a);
    return {16'hA5A5, a[15:0], 32'(a * 3 + 7)};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // responder and per-clock reference comparison
  initial begin
    mem_ready = 1'b0; hreq_ready = 1'b0; hrsp_valid = 1'b0;
    hrsp_code = 2'b00; hrsp_data = '0; mem_rdata = '0; rd_next = '0;
    hdelay = 0; phase = 0; prev_rd = 1'b0; cyc = 0; ref_bias = '0;
    ph_addr = '0; ph_we = 1'b0; ph_mod = 1'b0; ph_wd = '0; ph_wbd = '0;
    h_code = 2'b00; h_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        logic host_take;
        int   a;
        // R8: read return one cycle after memory accept
        chk(dev_rvalid == prev_rd, "R8 rvalid timing", 64'(dev_rvalid), 64'(prev_rd));
        if (dev_rvalid) begin
          if (exp_q.size() == 0) chk(1'b0, "R8 unexpected read data", dev_rdata, 64'h0);
          else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            chk(dev_rdata == e, "R8 read data", dev_rdata, e);
          end
        end
        // phase-based ordering checks
        if (phase != 1) chk(!hreq_valid, "R3 host request outside resolution", 64'(hreq_valid), 64'h0);
        case (phase)
          1: begin
            chk(!mem_valid, "R4 memory touched before host answer", 64'(mem_valid), 64'h0);
            chk(!dev_ready, "R6 ready during resolution", 64'(dev_ready), 64'h0);
            if (hreq_valid) chk(hreq_addr == ph_addr, "R4 host request address", 64'(hreq_addr), 64'(ph_addr));
          end
          2: begin
            chk(!dev_ready, "R6 ready during write-back", 64'(dev_ready), 64'h0);
            chk(mem_valid && mem_we && mem_addr == ph_addr && mem_wdata == ph_wbd,
                "R5 write-back beat", mem_wdata, ph_wbd);
          end
          3: begin
            chk(!dev_ready, "R6 ready during replay", 64'(dev_ready), 64'h0);
            chk(mem_valid && mem_we == ph_we && mem_addr == ph_addr,
                "R4 replay of original access", 64'(mem_addr), 64'(ph_addr));
            if (ph_we) chk(mem_wdata == ph_wd, "R4 replay write data", mem_wdata, ph_wd);
          end
          default: ;
        endcase
        // R7: flip gating
        host_take = (phase == 0) && dev_valid && dev_ready && !ref_bias[dev_addr[15:12]];
        if (bc_valid) begin
          if ((phase != 0 && bc_page == ph_addr[15:12]) || (host_take && bc_page == dev_addr[15:12]))
            chk(!bc_ready, "R7 flip on busy page", 64'(bc_ready), 64'h0);
          else
            chk(bc_ready, "R7 flip on free page", 64'(bc_ready), 64'h1);
        end
        // memory port
        prev_rd = mem_valid && mem_ready && !mem_we;
        if (mem_valid && mem_ready) begin
          a = int'(mem_addr);
          if (mem_we) begin mem[a] = mem_wdata; act_wr++; end
          else rd_next = mem.exists(a) ? mem[a] : dflt(a);
          if (phase == 3) phase = 0;
          else if (phase == 2) phase = 3;
        end
        // host port
        if (hreq_valid && hreq_ready) begin
          a = int'(hreq_addr);
          act_hreq++;
          if (host_mod.exists(a)) begin
            h_code = 2'b01; h_data = host_mod[a]; host_mod.delete(a);
          end else begin
            h_code = 2'b00; h_data = 64'hBAD0_BAD0_BAD0_BAD0;
          end
          hdelay = 3;
        end
        if (hrsp_valid && phase == 1) phase = ph_mod ? 2 : 3;
        // reference step on device acceptance
        if (dev_valid && dev_ready) begin
          a = int'(dev_addr);
          if (!ref_bias[dev_addr[15:12]]) begin
            ref_hreq++;
            phase = 1; ph_addr = dev_addr; ph_we = dev_we; ph_wd = dev_wdata;
            ph_mod = ref_hmod.exists(a);
            if (ph_mod) begin
              ph_wbd = ref_hmod[a]; ref_mem[a] = ref_hmod[a]; ref_wr++; ref_hmod.delete(a);
            end
          end
          if (dev_we) begin ref_mem[a] = dev_wdata; ref_wr++; end
          else exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : dflt(a));
        end
        if (bc_valid && bc_ready) ref_bias[bc_page] = bc_bias;
      end
      @(posedge clk); #1;
      cyc++;
      mem_ready  = !mem_bp || (cyc % 3 != 0);
      hreq_ready = !host_bp || (cyc % 2 == 0);
      mem_rdata  = rd_next;
      hrsp_valid = 1'b0;
      if (hdelay > 0) begin
        hdelay--;
        if (hdelay == 0) begin hrsp_valid = 1'b1; hrsp_code = h_code; hrsp_data = h_data; end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  task automatic dev_acc(input logic we, input logic [15:0] addr, input logic [63:0] data);
    dev_valid = 1'b1; dev_we = we; dev_addr = addr; dev_wdata = data;
    forever begin
      @(negedge clk);
      if (dev_ready) break;
    end
    @(posedge clk); #1;
    dev_valid = 1'b0;
  endtask

  task automatic bc_set(input logic [3:0] pg, input logic b);
    bc_valid = 1'b1; bc_page = pg; bc_bias = b;
    forever begin
      @(negedge clk);
      if (bc_ready) break;
    end
    @(posedge clk); #1;
    bc_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk);
    while (phase != 0 || hdelay != 0 || exp_q.size() != 0 || dev_rvalid);
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    int h0;
    rst_n = 1'b0; dev_valid = 1'b0; dev_we = 1'b0; dev_addr = '0; dev_wdata = '0;
    bc_valid = 1'b0; bc_page = '0; bc_bias = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!dev_rvalid, "R1 rvalid in reset", 64'(dev_rvalid), 64'h0);
    chk(!hreq_valid, "R1 host request in reset", 64'(hreq_valid), 64'h0);
    chk(!mem_valid, "R1 memory request in reset", 64'(mem_valid), 64'h0);
    chk(bc_ready, "R1 command ready in reset", 64'(bc_ready), 64'h1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: every page starts host-shared
    h0 = act_hreq;
    for (int p = 0; p < 16; p++) dev_acc(1'b0, {p[3:0], 12'h010}, '0);
    wait_idle();
    chk(act_hreq - h0 == 16, "R1 all pages host-shared", 64'(act_hreq - h0), 64'd16);

    // R3: device-owned pages raise no host request
    bc_set(4'h2, 1'b1);
    bc_set(4'h5, 1'b1);
    h0 = act_hreq;
    dev_acc(1'b1, 16'h2008, 64'h0123_4567_89AB_CDEF);
    dev_acc(1'b0, 16'h2008, '0);
    dev_acc(1'b1, 16'h5100, 64'hFEED_0000_0000_0001);
    dev_acc(1'b0, 16'h5100, '0);
    dev_acc(1'b0, 16'h2FF8, '0);
    wait_idle();
    chk(act_hreq - h0 == 0, "R3 no host requests on device pages", 64'(act_hreq - h0), 64'd0);

    // R4/R5: host-shared with modified and clean lines
    host_mod[16'h7040] = 64'h1111_2222_3333_4444; ref_hmod[16'h7040] = 64'h1111_2222_3333_4444;
    host_mod[16'h7048] = 64'h5555_6666_7777_8888; ref_hmod[16'h7048] = 64'h5555_6666_7777_8888;
    h0 = act_hreq;
    dev_acc(1'b0, 16'h7040, '0);
    dev_acc(1'b1, 16'h7048, 64'h9999_AAAA_BBBB_CCCC);
    dev_acc(1'b0, 16'h7050, '0);
    dev_acc(1'b0, 16'h7048, '0);
    wait_idle();
    chk(act_hreq - h0 == 4, "R4 one host request per access", 64'(act_hreq - h0), 64'd4);
    chk(act_wr == ref_wr, "R5 write-back count", 64'(act_wr), 64'(ref_wr));

    // R2: page boundary
    bc_set(4'h3, 1'b1);
    h0 = act_hreq;
    dev_acc(1'b0, 16'h3FF8, '0);
    wait_idle();
    chk(act_hreq - h0 == 0, "R2 last line of device page", 64'(act_hreq - h0), 64'd0);
    dev_acc(1'b0, 16'h4000, '0);
    wait_idle();
    chk(act_hreq - h0 == 1, "R2 first line of next page", 64'(act_hreq - h0), 64'd1);

    // R7: flip held while its page is resolved
    host_bp = 1'b1;
    dev_acc(1'b0, 16'h9010, '0);
    bc_valid = 1'b1; bc_page = 4'h9; bc_bias = 1'b1;
    @(negedge clk);
    chk(!bc_ready, "R7 busy page flip stalled", 64'(bc_ready), 64'h0);
    @(posedge clk); #1;
    bc_page = 4'hA;
    @(negedge clk);
    chk(bc_ready, "R7 other page flip accepted", 64'(bc_ready), 64'h1);
    @(posedge clk); #1;
    bc_valid = 1'b0;
    bc_set(4'h9, 1'b1);
    wait_idle();
    h0 = act_hreq;
    dev_acc(1'b0, 16'h9020, '0);
    wait_idle();
    chk(act_hreq - h0 == 0, "R2 flip applied after resolution", 64'(act_hreq - h0), 64'd0);

    // mixed traffic under stalls on both sides
    mem_bp = 1'b1;
    host_mod[16'h6008] = 64'hCAFE_F00D_0000_6008; ref_hmod[16'h6008] = 64'hCAFE_F00D_0000_6008;
    h0 = act_hreq;
    for (int i = 0; i < 24; i++) begin
      logic [3:0] pg;
      case (i % 4)
        0: pg = 4'h2;
        1: pg = 4'h6;
        2: pg = 4'hA;
        default: pg = 4'h7;
      endcase
      dev_acc(i % 3 == 0, {pg, 12'(i * 8)}, {32'(i), 32'hFACE_0000 | 32'(i)});
    end
    wait_idle();
    chk(act_hreq - h0 == 12, "R4 host requests in mixed traffic", 64'(act_hreq - h0), 64'd12);

    // R2: return a page to host-shared for read-back
    mem_bp = 1'b0; host_bp = 1'b0;
    bc_set(4'h2, 1'b0);
    h0 = act_hreq;
    dev_acc(1'b0, 16'h2008, '0);
    wait_idle();
    chk(act_hreq - h0 == 1, "R2 page returned to host-shared", 64'(act_hreq - h0), 64'd1);

    chk(act_wr == ref_wr, "R5 memory write count", 64'(act_wr), 64'(ref_wr));
    foreach (ref_mem[k]) begin
      chk(mem.exists(k) && mem[k] == ref_mem[k], "R3 final memory contents",
          mem.exists(k) ? mem[k] : 64'h0, ref_mem[k]);
    end

    summary();
    $finish;
  end

endmodule